// File: doc/BRIEF.md
# Run-time input source selector

This block drives one input line of a circuit element from a source chosen at run time. A host writes a small configuration word. The word picks one of four sources: a default high level, a constant level, a single one-shot pulse of either polarity, or any one line of a shared internal signal bus. That bus carries the outputs of the other elements and the field inputs. When the bus is chosen, the line follows the selected bus bit with no register in the path. This means every element that names the same bus bit sees the same net.

The block also watches the line it drives. Two synchronizer flops and an edge register feed an edge detector. The detector can be set to respond to rising edges, falling edges, both, or neither. A detected edge raises a one-cycle interrupt request. A minimum-interval throttle stops a fast signal from flooding the host. Edges that the throttle drops set a sticky flag, and the next configuration write clears it.

Top module: `src_route_sel`

## Requirements
- R1: After reset, `sel_out` is 1, `irq` is 0 and `irq_dropped` is 0.
- R2: Mode code 2'b00 holds `sel_out` at 1, whatever the values of `cfg_level` and `sig_bus`.
- R3: Mode code 2'b01 holds `sel_out` at the `cfg_level` value written, from the cycle after the write.
- R4: A write with mode code 2'b10 fires a one-shot pulse. With `cfg_level`=1, `sel_out` is 1 for exactly PULSE_CYC cycles, starting in the cycle after the write, and then rests at 0. With `cfg_level`=0, it is 0 for PULSE_CYC cycles and then rests at 1.
- R5: A pulse write that arrives while a pulse is running restarts the timer. `sel_out` then stays at the active level for PULSE_CYC cycles counted from the later write.
- R6: Mode code 2'b11 makes `sel_out` equal `sig_bus[cfg_index]` in the same cycle, with no register in the path.
- R7: With rising-edge detection enabled (`cfg_edge` bit 0) and the throttle idle, a 0-to-1 change on the selected line makes `irq` high after the third rising clock edge that follows the change.
- R8: `cfg_edge` bit 1 enables falling edges and bit 0 enables rising edges. An edge of a kind that is not enabled raises no `irq` and does not set `irq_dropped`.
- R9: Two `irq` pulses are at least GAP_CYC+1 cycles apart. An enabled edge that arrives within that interval raises no `irq`. Once the interval has elapsed, an enabled edge raises `irq` again.
- R10: An enabled edge that the throttle drops sets `irq_dropped`. The flag stays set until the next configuration write, which clears it.
- R11: Each `irq` assertion lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Source mode: 00 high, 01 constant, 10 pulse, 11 bus |
| cfg_level | input | 1 | Constant value, or active level of the pulse |
| cfg_index | input | $clog2(BUS_W) | Bus bit to route in bus mode |
| cfg_edge | input | 2 | Interrupt edge enables: bit 0 rising, bit 1 falling |
| sig_bus | input | BUS_W | Shared internal signal bus |
| sel_out | output | 1 | Driven circuit-element input |
| irq | output | 1 | One-cycle interrupt request |
| irq_dropped | output | 1 | Sticky flag: an edge was throttled |

## Verification
A corrupted mode or level register shows up on `sel_out` in the very next cycle after a write. The routed bus bit is visible in the same cycle the bus changes. A pulse counter that is off by even one count changes the measured pulse length, and a missed reload is exposed by the restart case. Faults in the synchronizer or the throttle counter move the `irq` pulse away from its fixed three-edge latency, or let a second pulse through inside the interval. A wrong sticky flag is seen directly on `irq_dropped` a few cycles after the dropped edge.

// File: rtl/src_route_pkg.sv
package src_route_pkg;
    typedef enum logic [1:0] {
        SRC_HIGH  = 2'b00,
        SRC_CONST = 2'b01,
        SRC_PULSE = 2'b10,
        SRC_BUS   = 2'b11
    } src_mode_e;
endpackage

// File: rtl/src_route_cfg.sv
module src_route_cfg
    import src_route_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [1:0]       mode_in,
    input  logic             level_in,
    input  logic [IDX_W-1:0] index_in,
    input  logic [1:0]       edge_in,
    output src_mode_e        mode_q,
    output logic             level_q,
    output logic [IDX_W-1:0] index_q,
    output logic [1:0]       edge_q
);
    typedef struct packed {
        src_mode_e        mode;
        logic             level;
        logic [IDX_W-1:0] idx;
        logic [1:0]       edg;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.mode  = src_mode_e'(mode_in);
            st_d.level = level_in;
            st_d.idx   = index_in;
            st_d.edg   = edge_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{mode: SRC_HIGH, level: 1'b0, idx: '0, edg: 2'b00};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_q  = st_q.mode;
    assign level_q = st_q.level;
    assign index_q = st_q.idx;
    assign edge_q  = st_q.edg;
endmodule

// File: rtl/src_route_pulse.sv
module src_route_pulse #(
    parameter int PULSE_CYC = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic cancel,
    output logic active
);
    localparam int CNT_W = $clog2(PULSE_CYC + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pulse_t;

    pulse_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fire) begin
            st_d.cnt = CNT_W'(PULSE_CYC);
        end else if (cancel) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign active = (st_q.cnt != '0);
endmodule

// File: rtl/src_route_edge.sv
module src_route_edge #(
    parameter int GAP_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line,
    input  logic rise_en,
    input  logic fall_en,
    input  logic clr,
    output logic irq,
    output logic dropped
);
    localparam int GAP_W = $clog2(GAP_CYC + 1);

    typedef struct packed {
        logic [2:0]       sync;
        logic [GAP_W-1:0] gap;
        logic             irq;
        logic             drop;
    } edge_t;

    edge_t st_d, st_q;
    logic  rise, fall, hit;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[1:0], line};
        st_d.irq  = 1'b0;
        rise      = st_q.sync[1] & ~st_q.sync[2];
        fall      = ~st_q.sync[1] & st_q.sync[2];
        hit       = (rise & rise_en) | (fall & fall_en);
        if (st_q.gap != '0) begin
            st_d.gap = st_q.gap - GAP_W'(1);
        end
        if (hit) begin
            if (st_q.gap == '0) begin
                st_d.irq = 1'b1;
                st_d.gap = GAP_W'(GAP_CYC);
            end else begin
                st_d.drop = 1'b1;
            end
        end
        if (clr) begin
            st_d.drop = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{sync: 3'b111, gap: '0, irq: 1'b0, drop: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign irq     = st_q.irq;
    assign dropped = st_q.drop;
endmodule

// File: rtl/src_route_sel.sv
module src_route_sel
    import src_route_pkg::*;
#(
    parameter int BUS_W     = 32,
    parameter int PULSE_CYC = 300,
    parameter int GAP_CYC   = 1000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [1:0]               cfg_mode,
    input  logic                     cfg_level,
    input  logic [$clog2(BUS_W)-1:0] cfg_index,
    input  logic [1:0]               cfg_edge,
    input  logic [BUS_W-1:0]         sig_bus,
    output logic                     sel_out,
    output logic                     irq,
    output logic                     irq_dropped
);
    localparam int IDX_W = $clog2(BUS_W);

    src_mode_e        mode_q;
    logic             level_q;
    logic [IDX_W-1:0] index_q;
    logic [1:0]       edge_q;
    logic             fire, cancel, pulse_on;

    assign fire   = cfg_we && (cfg_mode == 2'(SRC_PULSE));
    assign cancel = cfg_we && !fire;

    src_route_cfg #(.IDX_W(IDX_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .mode_in  (cfg_mode),
        .level_in (cfg_level),
        .index_in (cfg_index),
        .edge_in  (cfg_edge),
        .mode_q   (mode_q),
        .level_q  (level_q),
        .index_q  (index_q),
        .edge_q   (edge_q)
    );

    src_route_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (fire),
        .cancel (cancel),
        .active (pulse_on)
    );

    always_comb begin
        case (mode_q)
            SRC_HIGH:  sel_out = 1'b1;
            SRC_CONST: sel_out = level_q;
            SRC_PULSE: sel_out = pulse_on ? level_q : ~level_q;
            default:   sel_out = sig_bus[index_q];
        endcase
    end

    src_route_edge #(.GAP_CYC(GAP_CYC)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .line    (sel_out),
        .rise_en (edge_q[0]),
        .fall_en (edge_q[1]),
        .clr     (cfg_we),
        .irq     (irq),
        .dropped (irq_dropped)
    );
endmodule

// File: rtl/src_route_sel_chk.sv
module src_route_sel_chk #(
    parameter int GAP_CYC = 1000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_we,
    input logic [1:0] cfg_mode,
    input logic       cfg_level,
    input logic       sel_out,
    input logic       irq,
    input logic       irq_dropped
);
    localparam int SW = $clog2(GAP_CYC + 1);

    logic [SW-1:0] since_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= SW'(GAP_CYC);
        end else if (irq) begin
            since_q <= '0;
        end else if (since_q != SW'(GAP_CYC)) begin
            since_q <= since_q + SW'(1);
        end
    end

    a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_mode == 2'b00) |=> sel_out);

    a_r3_const_level: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_mode == 2'b01) |=> (sel_out == $past(cfg_level)));

    a_r4_pulse_lead: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_mode == 2'b10) |=> (sel_out == $past(cfg_level)));

    a_r9_irq_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (since_q >= SW'(GAP_CYC)));

    a_r10_drop_clear: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !irq_dropped);

    a_r10_drop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_dropped && !cfg_we) |=> irq_dropped);

    a_r11_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
endmodule

bind src_route_sel src_route_sel_chk #(.GAP_CYC(GAP_CYC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_mode    (cfg_mode),
    .cfg_level   (cfg_level),
    .sel_out     (sel_out),
    .irq         (irq),
    .irq_dropped (irq_dropped)
);

// File: tb/sim_src_route_sel.sv
`timescale 1ns/1ps
module sim_src_route_sel;
    localparam int BUS_W = 8;
    localparam int PW    = 8;
    localparam int GAP   = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [1:0]       cfg_mode = 2'b00;
    logic             cfg_level = 1'b0;
    logic [2:0]       cfg_index = 3'd0;
    logic [1:0]       cfg_edge = 2'b00;
    logic [BUS_W-1:0] sig_bus = '0;
    logic             sel_out, irq, irq_dropped;

    int checks = 0;
    int fails = 0;
    int irq_cnt = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    src_route_sel #(.BUS_W(BUS_W), .PULSE_CYC(PW), .GAP_CYC(GAP)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_level(cfg_level), .cfg_index(cfg_index), .cfg_edge(cfg_edge),
        .sig_bus(sig_bus), .sel_out(sel_out), .irq(irq), .irq_dropped(irq_dropped)
    );

    always @(posedge clk) begin
        #1;
        if (irq === 1'b1) irq_cnt++;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_cfg(input logic [1:0] m, input logic lv,
                             input logic [2:0] ix, input logic [1:0] ed);
        @(negedge clk);
        cfg_we = 1'b1; cfg_mode = m; cfg_level = lv; cfg_index = ix; cfg_edge = ed;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic t_reset();
        wait_n(3);
        chk("R1 sel_out", sel_out, 1);
        chk("R1 irq", irq, 0);
        chk("R1 dropped", irq_dropped, 0);
    endtask

    task automatic t_idle();
        sig_bus = '0;
        write_cfg(2'b00, 1'b0, 3'd2, 2'b00);
        chk("R2 high with bus 0", sel_out, 1);
        sig_bus = 8'h55;
        wait_n(2);
        chk("R2 high with bus 55", sel_out, 1);
    endtask

    task automatic t_const();
        write_cfg(2'b01, 1'b0, 3'd0, 2'b00);
        chk("R3 const 0", sel_out, 0);
        write_cfg(2'b01, 1'b1, 3'd0, 2'b00);
        chk("R3 const 1", sel_out, 1);
    endtask

    task automatic t_pulse(input logic pol);
        int n_act;
        write_cfg(2'b10, pol, 3'd0, 2'b00);
        chk("R4 pulse first cycle", sel_out, pol);
        n_act = 0;
        for (int i = 0; i < 2 * PW; i++) begin
            if (sel_out == pol) n_act++;
            @(negedge clk);
        end
        chk("R4 pulse width", n_act, PW);
        chk("R4 rest level", sel_out, !pol);
    endtask

    task automatic t_restart();
        int n_act;
        write_cfg(2'b10, 1'b1, 3'd0, 2'b00);
        wait_n(3);
        write_cfg(2'b10, 1'b1, 3'd0, 2'b00);
        n_act = 0;
        for (int i = 0; i < 2 * PW; i++) begin
            if (sel_out == 1'b1) n_act++;
            @(negedge clk);
        end
        chk("R5 restarted width", n_act, PW);
    endtask

    task automatic t_bus();
        logic [7:0] pats [4] = '{8'h20, 8'hDF, 8'h00, 8'hFF};
        write_cfg(2'b11, 1'b0, 3'd5, 2'b00);
        foreach (pats[k]) begin
            @(negedge clk);
            sig_bus = pats[k];
            #1;
            chk("R6 same-cycle route", sel_out, pats[k][5]);
        end
    endtask

    task automatic t_irq_throttle();
        int base;
        sig_bus = '0;
        write_cfg(2'b11, 1'b0, 3'd3, 2'b01);
        wait_n(40);
        base = irq_cnt;
        sig_bus[3] = 1'b1;
        wait_n(2);
        chk("R7 no irq before third edge", irq, 0);
        wait_n(1);
        chk("R7 irq after third edge", irq, 1);
        wait_n(1);
        chk("R11 irq one cycle", irq, 0);
        sig_bus[3] = 1'b0;
        wait_n(2);
        sig_bus[3] = 1'b1;
        wait_n(4);
        chk("R10 dropped set", irq_dropped, 1);
        chk("R9 edge in gap suppressed", irq_cnt, base + 1);
        wait_n(20);
        sig_bus[3] = 1'b0;
        wait_n(2);
        sig_bus[3] = 1'b1;
        wait_n(5);
        chk("R9 irq after interval", irq_cnt, base + 2);
        chk("R10 dropped sticky", irq_dropped, 1);
        write_cfg(2'b11, 1'b0, 3'd3, 2'b01);
        chk("R10 cleared by write", irq_dropped, 0);
    endtask

    task automatic t_edge_sel();
        int base;
        write_cfg(2'b11, 1'b0, 3'd3, 2'b10);
        wait_n(40);
        base = irq_cnt;
        sig_bus[3] = 1'b0;
        wait_n(6);
        chk("R8 falling enabled", irq_cnt, base + 1);
        wait_n(25);
        sig_bus[3] = 1'b1;
        wait_n(6);
        chk("R8 rising ignored", irq_cnt, base + 1);
        chk("R8 ignored edge not dropped", irq_dropped, 0);
        write_cfg(2'b11, 1'b0, 3'd3, 2'b00);
        wait_n(30);
        base = irq_cnt;
        sig_bus[3] = 1'b0;
        wait_n(4);
        sig_bus[3] = 1'b1;
        wait_n(6);
        chk("R8 no edges enabled", irq_cnt, base);
        chk("R8 none not dropped", irq_dropped, 0);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        wait_n(2);
        chk("R1 during reset", sel_out, 1);
        rst_n = 1'b1;
        t_reset();
        t_idle();
        t_const();
        t_pulse(1'b1);
        t_pulse(1'b0);
        t_restart();
        t_bus();
        t_irq_throttle();
        t_edge_sel();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule